// File: doc/BRIEF.md
# Clock Fanout with Runt-Free Output Enable

This block picks one of three reference clocks with a 2-bit select and copies the chosen clock to ten identical single-ended outputs. Each output is modelled as a data bit plus a drive-enable bit, which stands in for a three-state pad. When the drive-enable bit is low the pad is undriven, and the data bit then reads as 0.

A single enable input turns the whole fanout on and off. Turning it off takes effect on the next falling edge of the selected clock, so the last high pulse always completes. Turning it on drives every output low at once, asynchronously, so no clock edge is needed. The outputs then start following the clock after two falling edges of the selected clock have been seen with the enable high. The enable level is brought into the clock domain through a synchroniser clocked on falling edges.

A change of select while the clock runs may produce a short pulse. Integrators switch the select only while the references are low.

Top module: `fanoutClockBuffer`

## Requirements
- R1: While `rstN` is low, every `drvEn` bit is 0 and every `clkOut` bit is 0. Reset is asynchronous and active low.
- R2: The select `refSel` routes the reference as follows. Code 2'b00 picks `refPri`. Code 2'b01 picks `refSec`. Codes 2'b10 and 2'b11 both pick `refXtal`. A reference that is not selected has no effect on the outputs.
- R3: All ten `clkOut` bits are always equal to each other, and all ten `drvEn` bits are always equal to each other.
- R4: When `outEnable` has been low across a falling edge of the selected clock, and no rise of `outEnable` has followed, `drvEn` is 0 and `clkOut` is 0.
- R5: After `outEnable` falls, the outputs keep following the clock up to the next falling edge of the selected clock. `drvEn` drops at that edge.
- R6: When `outEnable` rises while the outputs are undriven, `drvEn` goes to all ones and `clkOut` to all zeros in the same step, with no clock edge.
- R7: After the drive is switched on, `clkOut` stays low until the second falling edge of the selected clock. From the next rising edge on, `clkOut` equals the selected clock.
- R8: If the clock is static, raising `outEnable` still forces the outputs low and driven. Lowering it again leaves them driven low until a falling edge arrives.
- R9: While out of reset, `clkOut` rises only together with a rise of the selected clock and falls only together with a fall of it, so no runt pulse appears.
- R10: A selected reference held at its open (constant low) level gives a constant low output while enabled.
- R11: If `outEnable` drops and returns with no falling edge of the selected clock in between, the outputs carry on without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| refSel | input | 2 | Reference select code |
| refPri | input | 1 | Primary reference clock |
| refSec | input | 1 | Secondary reference clock |
| refXtal | input | 1 | Crystal / bypass reference clock |
| outEnable | input | 1 | Fanout enable level |
| clkOut | output | 10 | Output clock data bits |
| drvEn | output | 10 | Output drive enables (1 = driven) |

## Verification
The bench drops the enable while the clock is high. A design that closed the gate at once would cut that pulse short, and one that waited for the synchroniser would keep driving one cycle too long. It raises the enable with the clock high and with the clock static, which exposes a design that needs an edge to leave the undriven state or that lets a stale gate pass a partial high pulse. A short enable dip with no falling edge inside it checks that the outputs are not interrupted. A sweep of all four select codes is run while the unselected references toggle in antiphase, so a wrong routing shows up as an inverted output.

// File: rtl/fanoutPkg.sv
package fanoutPkg;

  // Reference select codes; both crystal codes share one input
  localparam logic [1:0] SEL_PRI    = 2'b00;
  localparam logic [1:0] SEL_SEC    = 2'b01;
  localparam logic [1:0] SEL_XTAL   = 2'b10;
  localparam logic [1:0] SEL_BYPASS = 2'b11;

  // Strobes from the enable control to the fanout datapath
  typedef struct packed {
    logic drive;     // pads driven (not high impedance)
    logic gateOpen;  // clock passes to the pads
  } fanoutStrobes_t;

endpackage

// File: rtl/fanoutDatapath.sv
module fanoutDatapath
  import fanoutPkg::*;
#(
  parameter int NUM_OUT = 10
) (
  input  logic [1:0]         refSel,
  input  logic               refPri,
  input  logic               refSec,
  input  logic               refXtal,
  input  fanoutStrobes_t     strobes,
  output logic               selClk,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] drvEn
);

  always_comb begin
    unique case (refSel)
      SEL_PRI:    selClk = refPri;
      SEL_SEC:    selClk = refSec;
      SEL_XTAL:   selClk = refXtal;
      SEL_BYPASS: selClk = refXtal;
      default:    selClk = 1'b0;
    endcase
  end

  logic gatedClk;
  assign gatedClk = selClk & strobes.gateOpen & strobes.drive;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pad
    assign clkOut[i] = gatedClk;
    assign drvEn[i]  = strobes.drive;
  end

endmodule

// File: rtl/enableControl.sv
module enableControl
  import fanoutPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           rstN,
  input  logic           selClk,
  input  logic           outEnable,
  output fanoutStrobes_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  // Drive state: set at once by the enable, cleared only on a falling edge
  logic setReq;
  logic driveQ;
  assign setReq = outEnable & rstN;

  always_ff @(negedge selClk or posedge setReq or negedge rstN) begin
    if (!rstN)       driveQ <= 1'b0;
    else if (setReq) driveQ <= 1'b1;
    else             driveQ <= 1'b0;
  end

  // Synchroniser held clear while undriven, so a new enable always
  // starts from a closed gate
  logic syncClrN;
  logic [SYNC_STAGES-1:0] syncQ;
  assign syncClrN = rstN & driveQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(negedge selClk or negedge syncClrN) begin
        if (!syncClrN) syncQ[s] <= 1'b0;
        else           syncQ[s] <= outEnable;
      end
    end else begin : g_next
      always_ff @(negedge selClk or negedge syncClrN) begin
        if (!syncClrN) syncQ[s] <= 1'b0;
        else           syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign strobes.drive    = driveQ;
  assign strobes.gateOpen = syncQ[LAST];

endmodule

// File: rtl/fanoutClockBuffer.sv
module fanoutClockBuffer
  import fanoutPkg::*;
#(
  parameter int NUM_OUT     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rstN,
  input  logic [1:0]         refSel,
  input  logic               refPri,
  input  logic               refSec,
  input  logic               refXtal,
  input  logic               outEnable,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] drvEn
);

  fanoutStrobes_t strobes;
  logic           selClk;

  enableControl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .rstN      (rstN),
    .selClk    (selClk),
    .outEnable (outEnable),
    .strobes   (strobes)
  );

  fanoutDatapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .refSel  (refSel),
    .refPri  (refPri),
    .refSec  (refSec),
    .refXtal (refXtal),
    .strobes (strobes),
    .selClk  (selClk),
    .clkOut  (clkOut),
    .drvEn   (drvEn)
  );

endmodule

// File: rtl/fanoutBufferChecker.sv
module fanoutBufferChecker #(
  parameter int NUM_OUT = 10
) (
  input logic               rstN,
  input logic [1:0]         refSel,
  input logic               refPri,
  input logic               refSec,
  input logic               refXtal,
  input logic               outEnable,
  input logic [NUM_OUT-1:0] clkOut,
  input logic [NUM_OUT-1:0] drvEn
);

  logic refNow;
  assign refNow = refSel[1] ? refXtal : (refSel[0] ? refSec : refPri);

  // R9: output edges only coincide with matching reference edges
  always @(posedge clkOut[0]) begin
    if (rstN) assert_rise_with_ref_R9: assert (refNow);
  end
  always @(negedge clkOut[0]) begin
    if (rstN) assert_fall_with_ref_R9: assert (!refNow);
  end

  // R5: the drive drops only on a falling reference edge
  always @(negedge drvEn[0]) begin
    if (rstN) assert_drop_on_fall_R5: assert (!refNow);
  end

  // R3: all pads identical
  assert_pads_equal_R3: assert property (@(posedge refNow) disable iff (!rstN)
    (clkOut == {NUM_OUT{clkOut[0]}}) && (drvEn == {NUM_OUT{drvEn[0]}}));

  // R6: an enable high before a falling edge means the pads are driven
  assert_enable_drives_R6: assert property (@(negedge refNow) disable iff (!rstN)
    outEnable |-> (&drvEn));

endmodule

bind fanoutClockBuffer fanoutBufferChecker #(.NUM_OUT(NUM_OUT)) u_chk (.*);

// File: tb/test_fanoutClockBuffer.sv
module test_fanoutClockBuffer;

  localparam int N = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic         rstN = 1'b0;
  logic [1:0]   refSel = 2'b00;
  logic         refPri = 1'b0, refSec = 1'b0, refXtal = 1'b0;
  logic         outEnable = 1'b0;
  logic [N-1:0] clkOut, drvEn;

  fanoutClockBuffer i_fanoutClockBuffer (
    .rstN(rstN), .refSel(refSel), .refPri(refPri), .refSec(refSec),
    .refXtal(refXtal), .outEnable(outEnable), .clkOut(clkOut), .drvEn(drvEn)
  );

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [1:0] expQ[$];   // {drive, out}
  string      tagQ[$];

  // Bench model state, from the requirements
  bit mDrv = 0;
  int mFalls = 0;
  bit prevC = 0;

  task automatic step(input bit c, input bit oe, input bit noise, input string tag);
    bit fall;
    bit o;
    @(posedge clk);
    outEnable = oe;
    refPri  = (refSel == 2'b00) ? c : (noise ? ~c : 1'b0);
    refSec  = (refSel == 2'b01) ? c : (noise ? ~c : 1'b0);
    refXtal = refSel[1]         ? c : (noise ? ~c : 1'b0);
    fall = prevC && !c;
    if (!rstN) begin
      mDrv = 0; mFalls = 0;
    end else begin
      if (oe) begin
        if (!mDrv) mFalls = 0;
        mDrv = 1;
      end else if (fall) begin
        mDrv = 0;
      end
      if (!mDrv) mFalls = 0;
      else if (fall && mFalls < 2) mFalls++;
    end
    o = mDrv && (mFalls >= 2) && c;
    prevC = c;
    expQ.push_back({mDrv, o});
    tagQ.push_back(tag);
  endtask

  task automatic cycles(input int n, input bit oe, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, oe, 1'b1, tag);
      step(1'b0, oe, 1'b1, tag);
    end
  endtask

  task automatic changeSel(input logic [1:0] s);
    step(1'b0, outEnable, 1'b0, "R2");
    @(posedge clk);
    refSel = s;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      logic [N-1:0] eOut, eDrv;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      eDrv = {N{e[1]}};
      eOut = {N{e[0]}};
      vecCount++;
      if (clkOut !== eOut || drvEn !== eDrv) begin
        failCount++;
        $display("FAIL %s: clkOut=%b drvEn=%b expected clkOut=%b drvEn=%b",
                 t, clkOut, drvEn, eOut, eDrv);
      end
    end
  end

  initial begin
    // R1: reset state
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b1, "R1");
    @(posedge clk); rstN = 1'b0; outEnable = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R1");
    @(posedge clk); rstN = 1'b1;
    // R4: disabled
    cycles(3, 1'b0, "R4");
    // R6: enable with clock high -> driven low at once
    step(1'b1, 1'b1, 1'b1, "R6");
    // R7: low until second falling edge, then follow
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    cycles(4, 1'b1, "R3");
    // R5: enable falls while high; pulse completes, drive drops at fall
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, 1'b1, "R5");
    cycles(2, 1'b0, "R4");
    // R11: short dip without a falling edge
    cycles(3, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, "R11");
    step(1'b1, 1'b0, 1'b1, "R11");
    step(1'b1, 1'b1, 1'b1, "R11");
    step(1'b0, 1'b1, 1'b1, "R11");
    cycles(2, 1'b1, "R11");
    // disable, then R8: static clock
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, "R4");
    // R10: open (low) reference while enabled
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, "R10");
    cycles(3, 1'b1, "R7");
    // R2: select sweep with unselected references in antiphase
    changeSel(2'b01); cycles(4, 1'b1, "R2");
    changeSel(2'b10); cycles(4, 1'b1, "R2");
    changeSel(2'b11); cycles(4, 1'b1, "R2");
    changeSel(2'b00); cycles(4, 1'b1, "R2");
    // R1: reset mid-run, release with enable high and clock high
    step(1'b1, 1'b1, 1'b1, "R3");
    @(posedge clk); rstN = 1'b0;
    step(1'b1, 1'b1, 1'b1, "R1");
    @(posedge clk); rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1, "R6");
    cycles(4, 1'b1, "R7");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule